// File: doc/BRIEF.md
# Split Long Call and Short Jump Target Unit

This unit evaluates the branch-related 16-bit halfwords of a compact instruction stream. A long subroutine call does not fit in one halfword, so it is issued as a pair. The prefix halfword sign-extends its 11-bit field, scales it by 4096, adds it to the program counter and parks the partial target in the link register. The suffix halfword then adds its own 11-bit field, doubled, to that parked value with bit 0 forced low. The result becomes the new program counter. The link register is overwritten with the return address, which is the address of the next halfword with bit 0 set as a marker.

The same datapath resolves the unconditional short jump, whose 11-bit field is sign-extended, doubled and added to the program counter. The program counter presented to the unit is the address of the halfword plus 4. All sums wrap modulo 2^32. Any other halfword passes through with no effect. Results are registered and appear one clock after the input is accepted. A strobe marks every result that redirects the program counter, so a neighbouring fetch stage can flush on it.

Top module: `long_branch_link_unit`

## Requirements
- R1: Every cycle with `in_valid` high yields exactly one cycle of `out_valid` high on the following clock; no result appears without a preceding accepted input.
- R2: A prefix halfword (top five bits 11110) sets `out_lr` to `in_pc` plus the sign-extended 11-bit field shifted left by 12, raises `out_lr_we`, keeps `out_taken` low and presents `out_pc` equal to `in_pc`.
- R3: A suffix halfword (top five bits 11111) sets `out_pc` to `in_lr` with bit 0 cleared plus the zero-extended 11-bit field shifted left by 1, and raises `out_taken`.
- R4: A suffix halfword sets `out_lr` to `in_pc` minus 2 with bit 0 set and raises `out_lr_we`.
- R5: A short jump halfword (top five bits 11100) sets `out_pc` to `in_pc` plus the sign-extended 11-bit field shifted left by 1, raises `out_taken`, keeps `out_lr_we` low and presents `out_lr` equal to `in_lr`.
- R6: `out_taken` is high only in a cycle where `out_valid` is high and the program counter is redirected, for one cycle per redirecting halfword.
- R7: Any halfword whose top five bits match none of the three codes has no effect: `out_taken` and `out_lr_we` low, `out_pc` equal to `in_pc`, `out_lr` equal to `in_lr`.
- R8: All additions and the subtraction wrap modulo 2^32 with no saturation.
- R9: After a clock with `rst` high, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Halfword and register values are presented this cycle |
| in_insn | input | 16 | Instruction halfword |
| in_pc | input | 32 | Program counter (halfword address plus 4) |
| in_lr | input | 32 | Current link register value |
| out_valid | output | 1 | Result of the previous accepted halfword |
| out_taken | output | 1 | Program counter redirect strobe |
| out_pc | output | 32 | Next program counter value |
| out_lr_we | output | 1 | Link register write enable |
| out_lr | output | 32 | Value to write to the link register |

## Verification
Every result is due exactly one clock after its halfword is accepted, because the only register on the path is the output stage. The driver places a halfword on the falling edge and queues the expected result computed from the requirements. The monitor compares on each later falling edge where `out_valid` is high, which is the edge one cycle after the capture. Prefix and suffix are also sent back to back, with the suffix fed the link value the prefix produced, and the queue must be empty at the end so that no result is missing or extra.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_HI    = 2'd1,
    KIND_LO    = 2'd2,
    KIND_SHORT = 2'd3
  } br_kind_e;

  localparam int OPC_W = 5;
  localparam logic [OPC_W-1:0] OPC_SHORT = 5'b11100;
  localparam logic [OPC_W-1:0] OPC_HI    = 5'b11110;
  localparam logic [OPC_W-1:0] OPC_LO    = 5'b11111;

endpackage

// File: rtl/lbl_decode.sv
module lbl_decode
  import lbl_pkg::*;
#(
  parameter int INSN_W = 16,
  parameter int OFF_W  = 11
) (
  input  logic [INSN_W-1:0] insn,
  output br_kind_e          kind,
  output logic [OFF_W-1:0]  off
);

  logic [OPC_W-1:0] opc;

  assign opc = insn[INSN_W-1 -: OPC_W];
  assign off = insn[OFF_W-1:0];

  always_comb begin
    unique case (opc)
      OPC_HI:    kind = KIND_HI;
      OPC_LO:    kind = KIND_LO;
      OPC_SHORT: kind = KIND_SHORT;
      default:   kind = KIND_NONE;
    endcase
  end

endmodule

// File: rtl/lbl_target_calc.sv
module lbl_target_calc
  import lbl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 11
) (
  input  br_kind_e          kind,
  input  logic [OFF_W-1:0]  off,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] lr,
  output logic [ADDR_W-1:0] nxt_pc,
  output logic [ADDR_W-1:0] nxt_lr,
  output logic              nxt_lr_we,
  output logic              nxt_taken
);

  localparam int HI_SH = OFF_W + 1;
  localparam logic [ADDR_W-1:0] ONE = 1;
  localparam logic [ADDR_W-1:0] TWO = 2;

  logic [ADDR_W-1:0] off_sx, off_zx;
  logic [ADDR_W-1:0] hi_sum, lo_sum, short_sum, ret_addr, lr_even;

  assign off_sx    = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
  assign off_zx    = {{(ADDR_W-OFF_W){1'b0}}, off};
  assign lr_even   = {lr[ADDR_W-1:1], 1'b0};
  assign hi_sum    = pc + (off_sx << HI_SH);
  assign lo_sum    = lr_even + (off_zx << 1);
  assign short_sum = pc + (off_sx << 1);
  assign ret_addr  = (pc - TWO) | ONE;

  always_comb begin
    nxt_pc    = pc;
    nxt_lr    = lr;
    nxt_lr_we = 1'b0;
    nxt_taken = 1'b0;
    unique case (kind)
      KIND_HI: begin
        nxt_lr    = hi_sum;
        nxt_lr_we = 1'b1;
      end
      KIND_LO: begin
        nxt_pc    = lo_sum;
        nxt_lr    = ret_addr;
        nxt_lr_we = 1'b1;
        nxt_taken = 1'b1;
      end
      KIND_SHORT: begin
        nxt_pc    = short_sum;
        nxt_taken = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/long_branch_link_unit.sv
module long_branch_link_unit
  import lbl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 16,
  parameter int OFF_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] in_lr,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_pc,
  output logic              out_lr_we,
  output logic [ADDR_W-1:0] out_lr
);

  br_kind_e          kind;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] nxt_pc, nxt_lr;
  logic              nxt_lr_we, nxt_taken;

  lbl_decode #(.INSN_W(INSN_W), .OFF_W(OFF_W)) u_dec (
    .insn (in_insn),
    .kind (kind),
    .off  (off)
  );

  lbl_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_calc (
    .kind      (kind),
    .off       (off),
    .pc        (in_pc),
    .lr        (in_lr),
    .nxt_pc    (nxt_pc),
    .nxt_lr    (nxt_lr),
    .nxt_lr_we (nxt_lr_we),
    .nxt_taken (nxt_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
      out_pc    <= '0;
      out_lr_we <= 1'b0;
      out_lr    <= '0;
    end else begin
      out_valid <= in_valid;
      out_taken <= in_valid & nxt_taken;
      out_lr_we <= in_valid & nxt_lr_we;
      if (in_valid) begin
        out_pc <= nxt_pc;
        out_lr <= nxt_lr;
      end
    end
  end

  logic [OPC_W-1:0] opc_chk;
  assign opc_chk = in_insn[INSN_W-1 -: OPC_W];

  assert_result_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_prefix_no_redirect_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_chk == OPC_HI) |=> (!out_taken && out_lr_we && out_pc == $past(in_pc)));
  assert_suffix_marks_return_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_chk == OPC_LO) |=> (out_taken && out_lr_we && out_lr[0]));
  assert_short_keeps_link_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_chk == OPC_SHORT) |=> (out_taken && !out_lr_we && out_lr == $past(in_lr)));
  assert_taken_only_valid_R6: assert property (@(posedge clk) disable iff (rst)
    out_taken |-> out_valid);
  assert_other_no_effect_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_chk != OPC_HI && opc_chk != OPC_LO && opc_chk != OPC_SHORT)
    |=> (!out_taken && !out_lr_we && out_pc == $past(in_pc) && out_lr == $past(in_lr)));

endmodule

// File: tb/tb_long_branch_link_unit.sv
module tb_long_branch_link_unit;

  localparam int ADDR_W = 32;
  localparam int INSN_W = 16;

  typedef struct {
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] lr;
    logic              lr_we;
    logic              taken;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [INSN_W-1:0] in_insn = '0;
  logic [ADDR_W-1:0] in_pc = '0;
  logic [ADDR_W-1:0] in_lr = '0;
  logic              out_valid, out_taken, out_lr_we;
  logic [ADDR_W-1:0] out_pc, out_lr;

  int n_chk = 0;
  int n_bad = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  long_branch_link_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_pc(in_pc), .in_lr(in_lr), .out_valid(out_valid), .out_taken(out_taken),
    .out_pc(out_pc), .out_lr_we(out_lr_we), .out_lr(out_lr)
  );

  function automatic exp_t model(logic [15:0] insn, logic [31:0] pc, logic [31:0] lr, string tag);
    exp_t e;
    logic [31:0] sx, zx;
    sx = {{21{insn[10]}}, insn[10:0]};
    zx = {21'd0, insn[10:0]};
    e.pc = pc; e.lr = lr; e.lr_we = 1'b0; e.taken = 1'b0; e.tag = tag;
    case (insn[15:11])
      5'b11110: begin e.lr = pc + (sx << 12); e.lr_we = 1'b1; end
      5'b11111: begin e.pc = (lr & 32'hFFFF_FFFE) + (zx << 1);
                      e.lr = (pc - 32'd2) | 32'd1; e.lr_we = 1'b1; e.taken = 1'b1; end
      5'b11100: begin e.pc = pc + (sx << 1); e.taken = 1'b1; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic send(logic [15:0] insn, logic [31:0] pc, logic [31:0] lr, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_pc = pc; in_lr = lr;
    q.push_back(model(insn, pc, lr, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        n_chk++;
        if (q.size() == 0) begin
          n_bad++;
          $display("FAIL R1: result without input, got valid=1 expected valid=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (out_pc !== e.pc || out_lr !== e.lr || out_lr_we !== e.lr_we || out_taken !== e.taken) begin
            n_bad++;
            $display("FAIL %s: pc=%h lr=%h we=%b tk=%b expected pc=%h lr=%h we=%b tk=%b",
                     e.tag, out_pc, out_lr, out_lr_we, out_taken, e.pc, e.lr, e.lr_we, e.taken);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    exp_t pre;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    n_chk++;
    if (out_valid !== 1'b0 || out_taken !== 1'b0 || out_lr_we !== 1'b0 || out_pc !== '0 || out_lr !== '0) begin
      n_bad++;
      $display("FAIL R9: valid=%b taken=%b we=%b pc=%h lr=%h expected all zero",
               out_valid, out_taken, out_lr_we, out_pc, out_lr);
    end
    // R2 prefix, positive and negative field
    send(16'hF001, 32'h0000_1000, 32'h1234_5678, "R2 prefix positive");
    send(16'hF7FF, 32'h0000_8004, 32'h0, "R2 prefix negative");
    idle();
    // R3/R4 suffix, even and odd link
    send(16'hF810, 32'h0000_2004, 32'h0040_0000, "R3 R4 suffix even link");
    send(16'hF801, 32'h0000_3006, 32'h0040_0011, "R3 suffix odd link bit0 cleared");
    send(16'hFFFF, 32'h0000_0104, 32'h0000_1000, "R3 suffix max field unsigned");
    idle();
    // R5 short jumps
    send(16'hE010, 32'h0000_0200, 32'hCAFE_0001, "R5 short forward");
    send(16'hE7FE, 32'h0000_0200, 32'hCAFE_0002, "R5 short backward");
    // R8 wrap cases
    send(16'hE3FF, 32'hFFFF_FFF0, 32'h0, "R8 short wrap past top");
    send(16'hF400, 32'h0000_0004, 32'h0, "R8 prefix wrap below zero");
    send(16'hFFFF, 32'h0000_0000, 32'hFFFF_FFFF, "R8 R4 suffix wrap");
    idle();
    // R7 other halfwords
    send(16'h4000, 32'h0000_5004, 32'h0000_7777, "R7 other alu halfword");
    send(16'hD123, 32'h0000_6004, 32'h0000_8888, "R7 other conditional halfword");
    send(16'hE800, 32'h0000_6006, 32'h0000_9999, "R7 other code 11101");
    // R6 back to back pair, suffix uses prefix link result
    pre = model(16'hF012, 32'h0001_0004, 32'h0, "R6 pair prefix");
    send(16'hF012, 32'h0001_0004, 32'h0, "R6 pair prefix");
    send(16'hF834, 32'h0001_0006, pre.lr, "R6 pair suffix");
    idle();
    repeat (4) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d results missing, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule